// File: doc/BRIEF.md
# Single-Step Multi-Mode Shift Register

This block holds a W-bit word and, on each clock edge where the enable input is high, moves it by exactly one bit position. A 3-bit operation code picks the kind of move. The choices are a zero-fill move toward the MSB or the LSB, a rotation in either direction, and a sign-aware move in either direction. The same code also provides hold and parallel load. When the enable input is low the word and the flag both keep their values.

A sticky-free overflow flag sits beside the word. Every sign-aware move toward the MSB rewrites it. It is high when that move changed the sign bit, which means the signed value could not be doubled. Every other operation leaves the flag as it was. A synchronous reset clears both the word and the flag.

Top module: `shift_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the word and the flag to 0, whatever en and op are.
- R2: With en low, or with op=3'b000 (hold), the word and the flag keep their values.
- R3: op=3'b001 moves the word one place toward the MSB and puts 0 into bit 0.
- R4: op=3'b010 moves the word one place toward the LSB and puts 0 into bit W-1.
- R5: op=3'b011 rotates toward the MSB, so that old bit W-1 becomes bit 0. op=3'b100 rotates toward the LSB, so that old bit 0 becomes bit W-1.
- R6: op=3'b110 moves the word toward the LSB and leaves bit W-1 unchanged. For example, 10011100 becomes 11001110.
- R7: op=3'b101 moves the word toward the MSB and puts 0 into bit 0. It also sets the flag to old bit W-1 XOR old bit W-2. For example, 10011100 becomes 00111000 with the flag set.
- R8: Only op=3'b101 changes the flag. Every other op leaves it as it was.
- R9: op=3'b111 copies the load input into the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | rising-edge clock |
| rst | input | 1 | synchronous reset, active high |
| en | input | 1 | performs op on this edge |
| op | input | 3 | operation code |
| din | input | W | parallel load value |
| q | output | W | register contents |
| ovf | output | 1 | arithmetic-left overflow flag |

## Verification
Directed sequences are checked first. The first loads 10011100 and applies both sign-aware moves, which separates sign copying from zero fill. The second loads 11010111 and runs zero-fill and rotate moves in alternation, expecting 10101110, 01010111, 00101011 and then 10010101. This tells apart the end that receives the fill bit and the fill value. Sign-aware left moves from 0100_0000 and from 0010_0000 set and then clear the flag. Any non-arithmetic op that follows must leave the flag unchanged. Finally, a long stretch of random ops, enables, resets and loads is compared each cycle against a behavioural model.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [2:0]   op,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         ovf
);
  logic [W-1:0] nxt;

  always_comb begin
    case (op)
      3'b001:  nxt = {q[W-2:0], 1'b0};
      3'b010:  nxt = {1'b0, q[W-1:1]};
      3'b011:  nxt = {q[W-2:0], q[W-1]};
      3'b100:  nxt = {q[0], q[W-1:1]};
      3'b101:  nxt = {q[W-2:0], 1'b0};
      3'b110:  nxt = {q[W-1], q[W-1:1]};
      3'b111:  nxt = din;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      ovf <= 1'b0;
    end else if (en) begin
      q <= nxt;
      if (op == 3'b101) ovf <= q[W-1] ^ q[W-2];
    end
  end
endmodule

module shift_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [2:0]   op,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         ovf
);
  logic live;
  always_ff @(posedge clk) live <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) live && rst |=> (q == '0 && !ovf)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst || !live)
    (!en || op == 3'b000) |=> ($stable(q) && $stable(ovf))); // R2
  AST_ASHR_SIGN: assert property (@(posedge clk) disable iff (rst || !live)
    (en && op == 3'b110) |=> q[W-1] == $past(q[W-1])); // R6
  AST_ROTL_WRAP: assert property (@(posedge clk) disable iff (rst || !live)
    (en && op == 3'b011) |=> q[0] == $past(q[W-1])); // R5
  AST_ASHL_FLAG: assert property (@(posedge clk) disable iff (rst || !live)
    (en && op == 3'b101) |=> ovf == ($past(q[W-1]) ^ $past(q[W-2]))); // R7
  AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (rst || !live)
    (op != 3'b101) |=> $stable(ovf)); // R8
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst || !live)
    (en && op == 3'b111) |=> q == $past(din)); // R9
endmodule

bind shift_unit shift_unit_chk #(.W(W)) u_chk (.*);

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
  localparam int W = 8;
  logic clk = 0, rst = 1, en = 0;
  logic [2:0] op = 0;
  logic [W-1:0] din = 0;
  logic [W-1:0] q;
  logic ovf;
  int total = 0, bad = 0;
  logic [W-1:0] mq = 0;
  logic mov = 0;

  always #2.5 clk = ~clk;

  shift_unit #(.W(W)) u_shift_unit (.*);

  task automatic model();
    int v;
    if (rst) begin mq = 0; mov = 0; end
    else if (en) begin
      v = mq;
      case (op)
        3'd1: mq = W'(v * 2);
        3'd2: mq = W'(v / 2);
        3'd3: mq = W'(v * 2 + ((v >> (W-1)) & 1));
        3'd4: mq = W'(v / 2 + ((v & 1) << (W-1)));
        3'd5: begin
          mov = ((v >> (W-1)) & 1) != ((v >> (W-2)) & 1);
          mq = W'(v * 2);
        end
        3'd6: mq = W'(v / 2 + (v & (1 << (W-1))));
        3'd7: mq = din;
        default: ;
      endcase
    end
  endtask

  task automatic chk(string req, logic [W-1:0] eq, logic eo);
    total++;
    if (q !== eq || ovf !== eo) begin
      bad++;
      $display("FAIL %s q=%b ovf=%b expected q=%b ovf=%b", req, q, ovf, eq, eo);
    end
  endtask

  task automatic step(logic r, logic e, logic [2:0] o, logic [W-1:0] d, string req);
    rst = r; en = e; op = o; din = d;
    @(posedge clk); model();
    #1 chk(req, mq, mov);
  endtask

  task automatic expect_val(string req, logic [W-1:0] eq, logic eo);
    chk(req, eq, eo);
  endtask

  initial begin
    #1;
    step(1, 0, 0, 0, "R1");
    expect_val("R1 reset", 8'h00, 0);
    step(0, 1, 7, 8'b10011100, "R9");
    expect_val("R9 load", 8'b10011100, 0);
    step(0, 1, 6, 0, "R6");
    expect_val("R6 ashr", 8'b11001110, 0);
    step(0, 1, 7, 8'b10011100, "R9");
    step(0, 1, 5, 0, "R7");
    expect_val("R7 ashl", 8'b00111000, 1);
    step(0, 1, 7, 8'b11010111, "R9");
    expect_val("R8 load keeps flag", 8'b11010111, 1);
    step(0, 1, 1, 0, "R3");
    expect_val("R3 shl", 8'b10101110, 1);
    step(0, 1, 4, 0, "R5");
    expect_val("R5 cir", 8'b01010111, 1);
    step(0, 1, 2, 0, "R4");
    expect_val("R4 shr", 8'b00101011, 1);
    step(0, 1, 4, 0, "R5");
    expect_val("R5 cir", 8'b10010101, 1);
    step(0, 1, 3, 0, "R5");
    expect_val("R5 cil", 8'b00101011, 1);
    step(0, 0, 7, 8'hFF, "R2");
    expect_val("R2 en low", 8'b00101011, 1);
    step(0, 1, 0, 8'hFF, "R2");
    expect_val("R2 hold", 8'b00101011, 1);
    step(0, 1, 7, 8'b00100000, "R9");
    step(0, 1, 5, 0, "R7");
    expect_val("R7 no ovf", 8'b01000000, 0);
    step(0, 1, 5, 0, "R7");
    expect_val("R7 ovf", 8'b10000000, 1);
    step(0, 1, 6, 0, "R6");
    expect_val("R6 neg", 8'b11000000, 1);
    step(1, 1, 7, 8'hAA, "R1");
    expect_val("R1 reset", 8'h00, 0);
    for (int i = 0; i < 3000; i++)
      step(($urandom % 50) == 0, ($urandom % 5) != 0, 3'($urandom), 8'($urandom), "R8 random");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule